// File: doc/BRIEF.md
# Scrambled Interleaved Reed-Solomon Line Frame Encoder

The block turns one 84-bit user word per clock into one 120-bit parallel line frame. At a 40 MHz frame clock this is one frame every 25 ns, which feeds a 4.8 Gbps serializer. The user word holds 80 payload bits and a 4-bit slow-control nibble (two internal-control bits and two external-control bits). The nibble travels through the frame exactly like the payload.

The encoder builds each frame in four steps:
- It passes the user word through a self-synchronizing scrambler for DC balance.
- It puts a 4-bit header in front. The header is not scrambled and marks the frame as data or idle.
- It cuts the 88 header-plus-user bits into 22 four-bit symbols.
- It splits those symbols alternately between two Reed-Solomon (15,11) codewords over GF(16). Each codeword adds four parity symbols, so the frame carries 32 parity bits in all.

Because the symbols interleave, a burst of corrupted line bits lands on both codewords, and each word only sees a share of it. A frame is registered once, so it appears on the clock edge after its user word is presented.

Top module: `fec_frame_encoder`

## Requirements
- R1: While rst_ni is low, frame_valid_o and frame_o are zero. From the first rising edge after reset is released, frame_valid_o is high and a new frame is produced on every edge.
- R2: frame_o[119:116] holds the header. The header is 4'b0101 when user_valid_i was high, and 4'b0110 (idle) when it was low. The header is never scrambled.
- R3: frame_o[32+i] holds scrambled bit y[i] for i = 0..83. The bits are processed serially, bit 0 first, and the sequence continues across frames. The rule is y[i] = x[i] ^ y[i-2] ^ y[i-21]. After reset the 21 earlier outputs are taken as ones.
- R4: An idle frame scrambles an all-zero word. user_i has no effect on an idle frame other than through R3 history, which depends only on the scrambled output.
- R5: The slow-control nibble user_i[83:80] (internal control in 83:82, external control in 81:80) is scrambled and carried like the payload bits. Descrambling the received frames recovers all 84 bits.
- R6: The frame is split into 30 symbols. Symbol j is frame_o[119-4j -: 4]. Symbols 0..21 are header plus user bits, and symbols 22..29 are parity. Symbol j belongs to codeword j%2, where it is the coefficient of x^(14 - j/2).
- R7: Each codeword evaluates to zero at alpha^1, alpha^2, alpha^3 and alpha^4. The field is GF(16) with primitive polynomial x^4+x+1, and alpha = 4'b0010. This makes the parity the systematic remainder of the message shifted up by x^4.
- R8: The frame for the inputs sampled at a rising edge appears on frame_o right after that edge. The latency is one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Frame clock, one frame per rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| user_i | input | 84 | User word; bits 83:80 are slow control |
| user_valid_i | input | 1 | High: data frame; low: idle frame |
| frame_o | output | 120 | Header, scrambled user bits, parity |
| frame_valid_o | output | 1 | Frame on frame_o is valid |

## Verification
Idle-header insertion and scrambler-history advance fall in the same cycle: an idle frame must change the header and zero the scrambler input while the history keeps running. The bench provokes this by alternating data and idle frames, with random junk on user_i during the idle frames. It then compares every frame bit-exactly against its own behavioural encoder. It also descrambles the received frames independently, to confirm that idle words come back as zero and data words come back intact. A reset in mid-run re-seeds the history, and the bench checks that the next frames follow the fresh seed.

// File: rtl/fec_pkg.sv
package fec_pkg;
  localparam int SYM_W = 4;
  localparam int N_SYM = 15;
  localparam int K_SYM = 11;
  localparam int P_SYM = N_SYM - K_SYM;
  localparam logic [SYM_W-1:0] PRIM_LOW = 4'b0011;  // x^4 = x + 1

  typedef logic [SYM_W-1:0] sym_t;
  typedef logic [P_SYM-1:0][SYM_W-1:0] gen_t;  // index i = coeff of x^i, monic top implied
  typedef logic [N_SYM-1:0][SYM_W-1:0] cw_t;   // index d = coeff of x^d

  function automatic sym_t gf_mul(sym_t a, sym_t b);
    sym_t acc;
    sym_t sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < SYM_W; i++) begin
      if (b[i]) acc ^= sh;
      sh = {sh[SYM_W-2:0], 1'b0} ^ (sh[SYM_W-1] ? PRIM_LOW : '0);
    end
    return acc;
  endfunction

  function automatic sym_t gf_alpha_pow(int e);
    sym_t r;
    r = sym_t'(1);
    for (int i = 0; i < e; i++) r = gf_mul(r, sym_t'(2));
    return r;
  endfunction

  function automatic gen_t rs_gen_poly();
    logic [P_SYM:0][SYM_W-1:0] c;
    sym_t root;
    c    = '0;
    c[0] = sym_t'(1);
    for (int r = 1; r <= P_SYM; r++) begin
      root = gf_alpha_pow(r);
      for (int i = P_SYM; i >= 1; i--) c[i] = c[i-1] ^ gf_mul(c[i], root);
      c[0] = gf_mul(c[0], root);
    end
    return c[P_SYM-1:0];
  endfunction

  function automatic logic rs_syndromes_zero(cw_t cw);
    sym_t acc;
    sym_t ar;
    logic ok;
    ok = 1'b1;
    for (int r = 1; r <= P_SYM; r++) begin
      ar  = gf_alpha_pow(r);
      acc = '0;
      for (int d = N_SYM - 1; d >= 0; d--) acc = gf_mul(acc, ar) ^ cw[d];
      if (acc != '0) ok = 1'b0;
    end
    return ok;
  endfunction
endpackage

// File: rtl/fec_scrambler.sv
module fec_scrambler #(
  parameter int DATA_W = 84,
  parameter int TAP_A  = 2,
  parameter int TAP_B  = 21,
  parameter logic [TAP_B-1:0] SEED = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic [TAP_B-1:0]  state_o
);
  localparam int HIST_W = TAP_B;
  localparam int EXT_W  = HIST_W + DATA_W;

  logic [HIST_W-1:0] hist_q, hist_d;

  // bit 0 leaves first; ext[0 +: HIST_W] holds the previous outputs, oldest at 0
  always_comb begin : p_scr
    logic [EXT_W-1:0] ext;
    ext = '0;
    ext[HIST_W-1:0] = hist_q;
    for (int i = 0; i < DATA_W; i++)
      ext[HIST_W+i] = data_i[i] ^ ext[HIST_W+i-TAP_A] ^ ext[HIST_W+i-TAP_B];
    data_o = ext[HIST_W +: DATA_W];
    hist_d = ext[DATA_W +: HIST_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= SEED;
    else         hist_q <= hist_d;
  end

  assign state_o = hist_q;
endmodule

// File: rtl/fec_rs_encoder.sv
module fec_rs_encoder
  import fec_pkg::*;
(
  input  logic [K_SYM-1:0][SYM_W-1:0] msg_i,  // msg_i[k] = coeff of x^(k+P_SYM)
  output logic [P_SYM-1:0][SYM_W-1:0] par_o   // par_o[i] = coeff of x^i
);
  localparam gen_t GEN = rs_gen_poly();

  // unrolled LFSR division, highest-degree symbol first
  always_comb begin : p_div
    sym_t fb;
    logic [P_SYM-1:0][SYM_W-1:0] r;
    r = '0;
    for (int k = K_SYM - 1; k >= 0; k--) begin
      fb = msg_i[k] ^ r[P_SYM-1];
      for (int i = P_SYM - 1; i > 0; i--) r[i] = r[i-1] ^ gf_mul(fb, GEN[i]);
      r[0] = gf_mul(fb, GEN[0]);
    end
    par_o = r;
  end
endmodule

// File: rtl/fec_frame_encoder.sv
module fec_frame_encoder
  import fec_pkg::*;
#(
  parameter int USER_W     = 84,
  parameter int HDR_W      = 4,
  parameter int INTERLEAVE = 2,
  parameter int SCR_TAP_A  = 2,
  parameter int SCR_TAP_B  = 21,
  parameter logic [SCR_TAP_B-1:0] SCR_SEED = '1,
  parameter logic [HDR_W-1:0] HDR_DATA = 4'b0101,
  parameter logic [HDR_W-1:0] HDR_IDLE = 4'b0110
) (
  input  logic                                               clk_i,
  input  logic                                               rst_ni,
  input  logic [USER_W-1:0]                                  user_i,
  input  logic                                               user_valid_i,
  output logic [HDR_W+USER_W+INTERLEAVE*P_SYM*SYM_W-1:0]     frame_o,
  output logic                                               frame_valid_o
);
  localparam int MSG_W    = HDR_W + USER_W;
  localparam int MSG_SYMS = MSG_W / SYM_W;
  localparam int PAR_SYMS = INTERLEAVE * P_SYM;
  localparam int FRAME_W  = MSG_W + PAR_SYMS * SYM_W;

  logic [USER_W-1:0]    payload, scr;
  logic [SCR_TAP_B-1:0] scr_state;
  logic [HDR_W-1:0]     hdr;
  logic [MSG_SYMS-1:0][SYM_W-1:0] msg_sym;
  logic [INTERLEAVE-1:0][K_SYM-1:0][SYM_W-1:0] cw_msg;
  logic [INTERLEAVE-1:0][P_SYM-1:0][SYM_W-1:0] cw_par;
  logic [PAR_SYMS-1:0][SYM_W-1:0] par_sym;
  logic [FRAME_W-1:0] frame_d, frame_q;
  logic               valid_q;

  assign payload = user_valid_i ? user_i : '0;
  assign hdr     = user_valid_i ? HDR_DATA : HDR_IDLE;

  fec_scrambler #(
    .DATA_W(USER_W), .TAP_A(SCR_TAP_A), .TAP_B(SCR_TAP_B), .SEED(SCR_SEED)
  ) u_scr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .data_i (payload),
    .data_o (scr),
    .state_o(scr_state)
  );

  assign msg_sym = {hdr, scr};

  // frame symbol j (counted from MSB) goes to codeword j % INTERLEAVE
  for (genvar w = 0; w < INTERLEAVE; w++) begin : g_word
    for (genvar k = 0; k < K_SYM; k++) begin : g_msg
      assign cw_msg[w][K_SYM-1-k] = msg_sym[MSG_SYMS-1-(k*INTERLEAVE+w)];
    end

    fec_rs_encoder u_enc (
      .msg_i(cw_msg[w]),
      .par_o(cw_par[w])
    );

    for (genvar i = 0; i < P_SYM; i++) begin : g_par
      assign par_sym[PAR_SYMS-1-(i*INTERLEAVE+w)] = cw_par[w][P_SYM-1-i];
    end
  end

  assign frame_d = {msg_sym, par_sym};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '0;
      valid_q <= 1'b0;
    end else begin
      frame_q <= frame_d;
      valid_q <= 1'b1;
    end
  end

  assign frame_o       = frame_q;
  assign frame_valid_o = valid_q;

  // regroup the registered frame into codewords for the checks below
  cw_t chk_cw [INTERLEAVE];
  for (genvar w = 0; w < INTERLEAVE; w++) begin : g_chk
    for (genvar s = 0; s < N_SYM; s++) begin : g_sym
      assign chk_cw[w][N_SYM-1-s] = frame_q[FRAME_W-1-SYM_W*(s*INTERLEAVE+w) -: SYM_W];
    end

    a_r7_codeword_roots: assert property (@(posedge clk_i) disable iff (!rst_ni)
      frame_valid_o |-> rs_syndromes_zero(chk_cw[w]));
  end

  a_r1_frame_each_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> frame_valid_o);

  a_r2_header_kind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |-> frame_o[FRAME_W-1 -: HDR_W] == ($past(user_valid_i) ? HDR_DATA : HDR_IDLE));

  a_r3_history_is_frame_tail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |-> scr_state == frame_o[FRAME_W-HDR_W-1 -: SCR_TAP_B]);
endmodule

// File: tb/fec_frame_encoder_bench.sv
module fec_frame_encoder_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [83:0]  user = '0;
  logic         uv = 1'b0;
  logic [119:0] frame;
  logic         fv;
  int checks = 0;
  int fails  = 0;
  bit done = 1'b0;

  int gexp [15];
  int glog [16];
  int gc   [5];
  bit sq[$];  // transmit-side scrambler history
  bit rq[$];  // receive-side descrambler history

  always #5 clk = ~clk;

  fec_frame_encoder u_fec_frame_encoder (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .user_i       (user),
    .user_valid_i (uv),
    .frame_o      (frame),
    .frame_valid_o(fv)
  );

  function automatic int gmul(int a, int b);
    if (a == 0 || b == 0) return 0;
    return gexp[(glog[a] + glog[b]) % 15];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [119:0] act, input logic [119:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic seed_model();
    sq.delete();
    rq.delete();
    for (int i = 0; i < 21; i++) sq.push_back(1'b1);
  endtask

  task automatic build(input logic v, input logic [83:0] x, output logic [119:0] f);
    logic [83:0] s;
    logic [87:0] m;
    int c [15];
    bit y;
    for (int i = 0; i < 84; i++) begin
      y = x[i] ^ sq[19] ^ sq[0];
      s[i] = y;
      sq.push_back(y);
      void'(sq.pop_front());
    end
    m = {(v ? 4'b0101 : 4'b0110), s};
    f = '0;
    f[119:32] = m;
    for (int w = 0; w < 2; w++) begin
      for (int k = 0; k < 15; k++) c[k] = (k < 11) ? int'(m[87-4*(k*2+w) -: 4]) : 0;
      for (int i = 0; i < 11; i++)
        if (c[i] != 0)
          for (int d = 1; d <= 4; d++) c[i+d] = c[i+d] ^ gmul(c[i], gc[4-d]);
      for (int k = 11; k < 15; k++) f[119-4*(k*2+w) -: 4] = 4'(c[k]);
    end
  endtask

  task automatic step(input logic v, input logic [83:0] w);
    logic [119:0] e;
    logic [83:0]  xw, xr;
    bit ready, y, ok;
    int acc;
    xw = v ? w : '0;
    build(v, xw, e);
    uv = v;
    user = w;
    @(negedge clk);
    chk(fv === 1'b1, "R1 valid", 120'(fv), 120'(1));
    chk(frame === e, "R6 R8 frame", frame, e);
    chk(frame[119:116] === (v ? 4'b0101 : 4'b0110), "R2 header",
        120'(frame[119:116]), 120'(v ? 4'b0101 : 4'b0110));
    ok = 1'b1;
    for (int cw = 0; cw < 2; cw++)
      for (int r = 1; r <= 4; r++) begin
        acc = 0;
        for (int s = 0; s < 15; s++) acc = gmul(acc, gexp[r]) ^ int'(frame[119-4*(s*2+cw) -: 4]);
        if (acc != 0) ok = 1'b0;
      end
    chk(ok, "R7 syndromes", frame, e);
    ready = (rq.size() == 21);
    xr = '0;
    for (int i = 0; i < 84; i++) begin
      y = frame[32+i];
      if (rq.size() == 21) xr[i] = y ^ rq[19] ^ rq[0];
      rq.push_back(y);
      if (rq.size() > 21) void'(rq.pop_front());
    end
    if (ready) chk(xr === xw, "R3/R4/R5 descramble", 120'(xr), 120'(xw));
  endtask

  function automatic logic [83:0] rnd84();
    logic [95:0] t;
    t = {$urandom(), $urandom(), $urandom()};
    return t[83:0];
  endfunction

  initial begin
    gexp[0] = 1;
    for (int i = 1; i < 15; i++) begin
      gexp[i] = gexp[i-1] << 1;
      if (gexp[i] >= 16) gexp[i] = gexp[i] ^ 'h13;
    end
    for (int i = 0; i < 15; i++) glog[gexp[i]] = i;
    glog[0] = 0;
    gc[0] = 1;
    for (int i = 1; i < 5; i++) gc[i] = 0;
    for (int r = 1; r <= 4; r++) begin
      for (int i = 4; i >= 1; i--) gc[i] = gc[i-1] ^ gmul(gc[i], gexp[r]);
      gc[0] = gmul(gc[0], gexp[r]);
    end

    // R1 reset state
    @(negedge clk);
    @(negedge clk);
    chk(fv === 1'b0 && frame === '0, "R1 reset", frame, '0);
    rst_n = 1'b1;
    seed_model();

    // R3 fixed patterns, continuing history
    step(1'b1, '0);
    step(1'b1, '1);
    step(1'b1, {21{4'hA}});
    step(1'b1, {21{4'h5}});
    for (int i = 0; i < 30; i++) step(1'b1, rnd84());

    // R4 idle frames carry junk on user_i
    for (int i = 0; i < 10; i++) step(1'b0, rnd84());

    // R2 alternating data/idle
    for (int i = 0; i < 20; i++) step(i[0], rnd84());

    // R5 slow-control nibble walking ones
    for (int k = 0; k < 4; k++) step(1'b1, 84'(1) << (80 + k));
    step(1'b1, {4'hF, 80'h0});

    // R1 reset during operation
    rst_n = 1'b0;
    @(negedge clk);
    chk(fv === 1'b0 && frame === '0, "R1 mid reset", frame, '0);
    rst_n = 1'b1;
    seed_model();
    step(1'b0, '1);
    for (int i = 0; i < 25; i++) step(1'b1, rnd84());

    for (int i = 0; i < 200; i++) step(($urandom() % 4) != 0, rnd84());

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule